// File: doc/BRIEF.md
# Free-running capture timer

This block is a 16-bit up-counter that advances on a count-clock strobe while it is enabled. Four capture channels share the counter. Each channel watches its own input pin for a programmable edge. When that edge is seen, the channel copies the current count into its own capture register and raises a one-cycle interrupt. Capturing does not disturb the counter. When the counter wraps from its top value to zero, the block pulses an overflow interrupt and sets a sticky overflow flag. The flag stays set until software clears it.

Software reaches the block through a small register port. The write side is a single-cycle strobe with no handshake, and the read side is a combinational multiplexer selected by the address. Through this port software sets the per-channel edge modes, reads and clears the overflow flag, and reads the counter and the capture registers. The count strobe and the enable are plain level inputs from the surrounding clocking and control logic.

Top module: `ftc_capture_timer`

## Requirements
- R1: After reset, the counter, all capture registers, the edge configuration and the overflow flag read 0, and every interrupt output is low.
- R2: While run_en is 0 the counter is held at 0 whatever tick does. While run_en is 1 the counter rises by exactly one on each clock edge where tick is 1, and it holds when tick is 0.
- R3: A selected edge on a capture pin loads the count present in the cycle the synchronized edge is seen. On the third rising clock edge after the pin changes, that channel's capture register takes this count and its interrupt bit goes high for exactly one cycle.
- R4: A capture neither stops nor clears the counter. With tick held high, a pin change driven when the count is C captures C+2, and the counter keeps advancing.
- R5: When the counter holds FFFFH and tick is 1, the next edge loads 0000H, and ovf_irq is high for that one cycle only.
- R6: ovf_flag is set on the same edge as ovf_irq. It stays at 1 until a write to address 1 with data bit 0 equal to 0 clears it. A write to address 1 with bit 0 equal to 1 has no effect.
- R7: If a clearing write to address 1 lands in the same cycle as a wrap, the flag ends up at 1.
- R8: Each channel n has a 2-bit edge field at configuration bits [2n+1:2n], written at address 0. The codes are 00 = no detection, 01 = rising, 10 = falling and 11 = both. An edge that is not selected leaves the capture register and the interrupt unchanged.
- R9: A second selected edge overwrites the capture register with the newer count, whether or not the earlier value was read.
- R10: Driving run_en back to 0 returns the counter to 0 and keeps the capture registers and the overflow flag.
- R11: The read map is: address 0 is the edge configuration, address 1 is the overflow flag in bit 0, address 2 is the counter, and addresses 3 to 6 are the capture registers of channels 0 to 3. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count-clock enable strobe |
| run_en | input | 1 | Counter enable; 0 holds the counter at zero |
| cap_in | input | 4 | Asynchronous capture pins, one per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data (edge fields, or the flag clear in bit 0) |
| reg_rdata | output | 16 | Read data for reg_addr |
| cap_irq | output | 4 | Per-channel capture interrupt pulses |
| ovf_irq | output | 1 | Overflow interrupt pulse |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The checker assumes that tick, run_en and the register port are synchronous to clk and stable across each rising edge. It also assumes that each capture pin holds a level for at least two clocks, so that every pin change gives one clean synchronized edge. The bench drives every input on the falling edge and holds each pin level for several cycles. Whenever the expected captured count has to be fixed, the bench also keeps tick low.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int FTC_CNT_W  = 16;
  localparam int FTC_NUM_CH = 4;

  // read/write map
  localparam int FTC_A_CFG  = 0;
  localparam int FTC_A_STAT = 1;
  localparam int FTC_A_CNT  = 2;
  localparam int FTC_A_CAP0 = 3;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/ftc_counter.sv
module ftc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_hit_o,  // combinational: wrap on this edge
  output logic             wrap_irq_o   // registered pulse
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign wrap_hit_o = run_en && tick && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      wrap_irq_o <= 1'b0;
    end else begin
      wrap_irq_o <= wrap_hit_o;
      if (!run_en)   cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/ftc_cap_channel.sv
module ftc_cap_channel
  import ftc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  edge_sel_e        sel_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             irq_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   level, rise, fall, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level = sync_q[SYNC_STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_o <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= hit;
      if (hit) cap_o <= count_i;
    end
  end
endmodule

// File: rtl/ftc_regs.sv
module ftc_regs
  import ftc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3,
  localparam int CFG_W = 2 * NUM_CH
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [CFG_W-1:0]             wdata_i,
  output logic [CNT_W-1:0]             rdata_o,
  input  logic                         wrap_hit_i,
  input  logic [CNT_W-1:0]             count_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] caps_i,
  output logic [CFG_W-1:0]             cfg_o,
  output logic                         flag_o
);
  logic clr_req;

  assign clr_req = wr_i && (int'(addr_i) == FTC_A_STAT) && !wdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (wr_i && int'(addr_i) == FTC_A_CFG) cfg_o <= wdata_i;
      // a wrap in the same cycle beats the clear
      if (wrap_hit_i)   flag_o <= 1'b1;
      else if (clr_req) flag_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) == FTC_A_CFG)       rdata_o[CFG_W-1:0] = cfg_o;
    else if (int'(addr_i) == FTC_A_STAT) rdata_o[0] = flag_o;
    else if (int'(addr_i) == FTC_A_CNT)  rdata_o = count_i;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(addr_i) == FTC_A_CAP0 + i) rdata_o = caps_i[i];
    end
  end
endmodule

// File: rtl/ftc_capture_timer.sv
module ftc_capture_timer
  import ftc_pkg::*;
#(
  parameter int CNT_W       = FTC_CNT_W,
  parameter int NUM_CH      = FTC_NUM_CH,
  parameter int SYNC_STAGES = 2,
  localparam int CFG_W      = 2 * NUM_CH,
  localparam int ADDR_W     = $clog2(FTC_A_CAP0 + NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run_en,
  input  logic [NUM_CH-1:0] cap_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CFG_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0] cap_irq,
  output logic              ovf_irq,
  output logic              ovf_flag
);
  logic [CNT_W-1:0]             count_q;
  logic                         wrap_hit;
  logic [NUM_CH-1:0][CNT_W-1:0] cap_q;
  logic [CFG_W-1:0]             cfg_q;

  ftc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .tick       (tick),
    .count_o    (count_q),
    .wrap_hit_o (wrap_hit),
    .wrap_irq_o (ovf_irq)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    ftc_cap_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (cap_in[g]),
      .sel_i   (edge_sel_e'(cfg_q[2*g +: 2])),
      .count_i (count_q),
      .cap_o   (cap_q[g]),
      .irq_o   (cap_irq[g])
    );
  end

  ftc_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .rdata_o    (reg_rdata),
    .wrap_hit_i (wrap_hit),
    .count_i    (count_q),
    .caps_i     (cap_q),
    .cfg_o      (cfg_q),
    .flag_o     (ovf_flag)
  );
endmodule

// File: rtl/ftc_capture_timer_chk.sv
module ftc_capture_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4,
  localparam int CFG_W = 2 * NUM_CH
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         run_en,
  input logic                         tick,
  input logic                         clr_wr,
  input logic [CNT_W-1:0]             count_q,
  input logic [NUM_CH-1:0][CNT_W-1:0] cap_q,
  input logic [CFG_W-1:0]             cfg_q,
  input logic [NUM_CH-1:0]            cap_irq,
  input logic                         ovf_irq,
  input logic                         ovf_flag
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> count_q == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !tick |=> $stable(count_q));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && tick && count_q == TOP |=> count_q == '0 && ovf_irq);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> count_q == '0);

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> ovf_flag);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !clr_wr |=> ovf_flag);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_cap_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cap_irq[i] |-> cap_q[i] == $past(count_q));

    p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_irq[i] |-> $stable(cap_q[i]));

    p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[2*i +: 2] == 2'b00 |=> !cap_irq[i]);
  end
endmodule

bind ftc_capture_timer ftc_capture_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .tick     (tick),
  .clr_wr   (reg_wr && (int'(reg_addr) == ftc_pkg::FTC_A_STAT) && !reg_wdata[0]),
  .count_q  (count_q),
  .cap_q    (cap_q),
  .cfg_q    (cfg_q),
  .cap_irq  (cap_irq),
  .ovf_irq  (ovf_irq),
  .ovf_flag (ovf_flag)
);

// File: tb/tb_ftc_capture_timer.sv
module tb_ftc_capture_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        run_en = 1'b0;
  logic [3:0]  cap_in = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  cap_irq;
  logic        ovf_irq;
  logic        ovf_flag;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  ftc_capture_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en), .cap_in(cap_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cap_irq(cap_irq), .ovf_irq(ovf_irq), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 v = reg_rdata;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic tickn(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  // drive a pin, return irqs at the cycle they should rise and the one after
  task automatic pin(input int ch, input logic v, output logic [3:0] now, output logic [3:0] nxt);
    @(negedge clk);
    cap_in[ch] = v;
    repeat (3) @(negedge clk);
    now = cap_irq;
    @(negedge clk);
    nxt = cap_irq;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(a, v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 reset irqs", {cap_irq, ovf_irq, ovf_flag}, 0);
  endtask

  task automatic t_enable();
    logic [15:0] v;
    tickn(5);
    rd(2, v); chk("R2 idle while disabled", v, 0);
    @(negedge clk) run_en = 1'b1;
    repeat (3) @(negedge clk);
    rd(2, v); chk("R2 no tick no count", v, 0);
    tickn(7);
    rd(2, v); chk("R2 counts ticks", v, 7);
  endtask

  task automatic t_rise();
    logic [15:0] v; logic [3:0] a, b;
    wr(0, 8'b11_10_01_01);
    rd(0, v); chk("R11 cfg readback", v, 16'h00E5);
    pin(0, 1'b1, a, b);
    chk("R3 irq rises", a, 4'b0001);
    chk("R3 irq one cycle", b, 4'b0000);
    rd(3, v); chk("R3 captured count", v, 7);
  endtask

  task automatic t_running();
    logic [15:0] c0, v;
    @(negedge clk);
    reg_addr = 3'd2;
    #1 c0 = reg_rdata;
    tick = 1'b1; cap_in[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 irq during count", cap_irq, 4'b0010);
    #1 v = reg_rdata;
    chk("R4 counter advanced", v, c0 + 16'd3);
    tick = 1'b0;
    rd(4, v); chk("R4 captured C+2", v, c0 + 16'd2);
  endtask

  task automatic t_fall();
    logic [15:0] v; logic [3:0] a, b;
    tickn(4);  // count 14
    pin(2, 1'b1, a, b);
    chk("R8 rise ignored in falling mode", a | b, 0);
    rd(5, v); chk("R8 cap2 untouched", v, 0);
    pin(2, 1'b0, a, b);
    chk("R8 falling captures irq", a, 4'b0100);
    rd(5, v); chk("R8 falling captured", v, 14);
  endtask

  task automatic t_both();
    logic [15:0] v; logic [3:0] a, b;
    pin(3, 1'b1, a, b);
    chk("R8 both mode rise", a, 4'b1000);
    rd(6, v); chk("R8 both rise value", v, 14);
    tickn(4);
    pin(3, 1'b0, a, b);
    chk("R8 both mode fall", a, 4'b1000);
    rd(6, v); chk("R8 both fall value", v, 18);
  endtask

  task automatic t_none();
    logic [15:0] v; logic [3:0] a, b;
    wr(0, 8'b11_10_01_00);
    pin(0, 1'b0, a, b); chk("R8 off ignores fall", a[0] | b[0], 0);
    tickn(2);
    pin(0, 1'b1, a, b); chk("R8 off ignores rise", a[0] | b[0], 0);
    rd(3, v); chk("R8 off keeps cap0", v, 7);
  endtask

  task automatic t_overwrite();
    logic [15:0] v, c; logic [3:0] a, b;
    pin(1, 1'b0, a, b);
    tickn(10);
    pin(1, 1'b1, a, b);
    tickn(3);
    pin(1, 1'b0, a, b);
    rd(2, c);
    pin(1, 1'b1, a, b);
    chk("R9 second irq", a, 4'b0010);
    rd(4, v); chk("R9 newer count kept", v, c);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    @(negedge clk) run_en = 1'b0;
    @(negedge clk) run_en = 1'b1;
    rd(2, v); chk("R10 disable clears counter", v, 0);
    rd(3, v); chk("R10 cap0 kept", v, 7);
    tickn(65535);
    rd(2, v); chk("R5 at top", v, 16'hFFFF);
    chk("R5 no early overflow", {ovf_irq, ovf_flag}, 0);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk("R5 overflow pulse", ovf_irq, 1);
    chk("R6 flag set with pulse", ovf_flag, 1);
    #1 rd(2, v); chk("R5 wrapped to zero", v, 0);
    chk("R5 pulse one cycle", ovf_irq, 0);
    tickn(20);
    chk("R6 flag sticky", ovf_flag, 1);
    wr(1, 8'h01);
    chk("R6 write 1 no effect", ovf_flag, 1);
    @(negedge clk) run_en = 1'b0;
    @(negedge clk);
    chk("R10 flag kept after disable", ovf_flag, 1);
    rd(6, v); chk("R10 cap3 kept", v, 18);
  endtask

  task automatic t_collision();
    logic [15:0] v;
    @(negedge clk) run_en = 1'b1;
    tickn(65535);
    @(negedge clk);
    tick = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h00; reg_wr = 1'b1;
    @(negedge clk);
    tick = 1'b0; reg_wr = 1'b0;
    chk("R7 wrap beats clear", ovf_flag, 1);
    wr(1, 8'h00);
    chk("R6 clear by write 0", ovf_flag, 0);
    rd(1, v); chk("R11 status read", v, 0);
    rd(7, v); chk("R11 unmapped reads 0", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_rise();
    t_running();
    t_fall();
    t_both();
    t_none();
    t_overwrite();
    t_wrap();
    t_collision();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule